// File: doc/BRIEF.md
# FRAM Identification Probe

This block identifies which ferroelectric SPI memory is attached. Software or a power-up sequencer pulses `start`. The block then runs a read-identification frame through a shared SPI byte shifter. It discards any leading continuation bytes and takes the first other byte as the manufacturer code, followed by two device bytes. Those two bytes are looked up in a device table that is held entirely in parameters. The result (a found flag, a table index, the memory size in bytes and the number of address bytes) is handed to the transaction sequencer. The sequencer uses it to shape later read and write commands.

Some parts give no identification and leave the data line floating high, so every ID byte reads as 0xFF. For those parts an optional fallback can be enabled by parameter. The block closes the first frame and opens a second one that reads the status register. If the status bits that are always zero on these parts really are zero, the block reports one preconfigured device. The fallback is never tried before the table lookup has failed.

The byte shifter interface is a simple handshake. The block raises `byte_go` for one cycle with the byte to send on `byte_tx`, while holding `spi_sel` high for the whole frame. The shifter answers with a one-cycle `byte_done` and the received byte on `byte_rx`.

Top module: `fram_id_probe`

## Requirements
- R1: After reset, `done`, `found`, `spi_sel` and `byte_go` are low, and all result outputs are zero.
- R2: A probe opens one frame with `spi_sel` high. Its first byte sent is 0x9F. Every later byte in that frame is sent as 0x00.
- R3: Received bytes equal to 0x7F are discarded until the first other byte arrives. That byte is the manufacturer code. The next two bytes are device byte 1 and device byte 2, whatever their values.
- R4: With manufacturer 0xC2 and a device byte pair exactly equal to a table entry, `found` is set and the entry is reported. The default table maps {22,00}→index 0, {22,01}→1, {23,00}→2, {23,01}→3, {24,00}→4 and {24,01}→5. Entries 0–1 report 32768 bytes with 2 address bytes, entries 2–3 report 65536 bytes with 2, and entries 4–5 report 131072 bytes with 3.
- R5: With manufacturer 0xC2 and no exact table match, the probe ends with `found` low, index, size and address length zero, and the three ID bytes visible on `id_mfr`, `id_dev1` and `id_dev2`.
- R6: Any manufacturer other than 0xC2 or 0xFF ends the probe without a second frame, with `found` low and the ID bytes kept.
- R7: With fallback enabled and manufacturer 0xFF, `spi_sel` drops, and a second frame sends 0x05 and reads one status byte. If status AND 0x31 is zero, `found` is set with index equal to the table length (6), 262144 bytes and 3 address bytes.
- R8: In the fallback, a status byte with bit 5, 4 or 0 set ends the probe with `found` low and no further frame.
- R9: With fallback disabled, manufacturer 0xFF ends the probe after the first frame with `found` low.
- R10: At most 9 bytes are read after the 0x9F command. If three ID bytes have not been collected by then, the probe fails with `found` low. Bytes never received read as zero.
- R11: `done` is a single-cycle pulse, coincident with the final results. Results are cleared at `start` and stay unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a probe (honoured only when idle) |
| done | output | 1 | One-cycle pulse: probe finished |
| found | output | 1 | A supported device was identified |
| dev_idx | output | 3 | Table index; table length means fallback device |
| mem_size | output | 32 | Memory size in bytes |
| addr_bytes | output | 2 | Number of address bytes for the device |
| id_mfr | output | 8 | Captured manufacturer byte |
| id_dev1 | output | 8 | Captured first device byte |
| id_dev2 | output | 8 | Captured second device byte |
| spi_sel | output | 1 | Chip select for the current frame, active high |
| byte_go | output | 1 | Request one byte exchange |
| byte_tx | output | 8 | Byte to shift out |
| byte_done | input | 1 | Byte exchange complete |
| byte_rx | input | 8 | Byte shifted in |

## Verification
The bench feeds ID streams with zero, two, six and seven leading continuation bytes, and one stream made entirely of continuation bytes. A design with an off-by-one read limit would either stop one byte early and miss an ID that just fits, or read a tenth byte. Near-miss device pairs that differ only in the revision byte catch a lookup that compares family bytes alone. In the floating-line case the bench drives status values that clear or set single fixed-zero bits, in both fallback settings. A design that tries the status read in the wrong order, tests the wrong bits, or ignores the enable would report a device where none is allowed, or open a second frame. A frame log in the shifter model counts the commands and the bytes exchanged per frame.

// File: rtl/fram_id_probe.sv
module fram_id_probe #(
  parameter int NUM_DEV = 6,
  parameter logic [NUM_DEV*16-1:0] DEV_IDS = {16'h2401, 16'h2400, 16'h2301, 16'h2300, 16'h2201, 16'h2200},
  parameter logic [NUM_DEV*16-1:0] DEV_KIB = {16'd128, 16'd128, 16'd64, 16'd64, 16'd32, 16'd32},
  parameter logic [NUM_DEV*2-1:0]  DEV_ALEN = {2'd3, 2'd3, 2'd2, 2'd2, 2'd2, 2'd2},
  parameter bit          FALLBACK_EN = 1'b1,
  parameter logic [15:0] FB_KIB = 16'd256,
  parameter logic [1:0]  FB_ALEN = 2'd3,
  parameter int MAX_RD = 9,
  parameter int SZ_W = 32,
  localparam int IW = $clog2(NUM_DEV + 1),
  localparam int CW = $clog2(MAX_RD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            done,
  output logic            found,
  output logic [IW-1:0]   dev_idx,
  output logic [SZ_W-1:0] mem_size,
  output logic [1:0]      addr_bytes,
  output logic [7:0]      id_mfr,
  output logic [7:0]      id_dev1,
  output logic [7:0]      id_dev2,
  output logic            spi_sel,
  output logic            byte_go,
  output logic [7:0]      byte_tx,
  input  logic            byte_done,
  input  logic [7:0]      byte_rx
);

  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] CONT    = 8'h7F;
  localparam logic [7:0] MFR_STD = 8'hC2;
  localparam logic [7:0] MFR_NONE = 8'hFF;
  localparam logic [7:0] SR_ZERO = 8'h31;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD_ID, S_RD_ID, S_EVAL, S_GAP, S_CMD_SR, S_RD_SR
  } st_t;

  st_t           st;
  logic          pend;
  logic [CW-1:0] cnt;
  logic [1:0]    pos;
  logic          hit;
  logic [IW-1:0] hit_idx;
  logic          got;

  assign spi_sel = (st == S_CMD_ID) || (st == S_RD_ID) || (st == S_CMD_SR) || (st == S_RD_SR);
  assign byte_go = spi_sel && !pend;
  assign byte_tx = (st == S_CMD_ID) ? OP_RDID : (st == S_CMD_SR) ? OP_RDSR : 8'h00;
  assign got     = pend && byte_done;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if ({id_dev1, id_dev2} == DEV_IDS[i*16 +: 16]) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pend <= 1'b0;
      cnt <= '0;
      pos <= '0;
      done <= 1'b0;
      found <= 1'b0;
      dev_idx <= '0;
      mem_size <= '0;
      addr_bytes <= '0;
      id_mfr <= '0;
      id_dev1 <= '0;
      id_dev2 <= '0;
    end else begin
      done <= 1'b0;
      if (byte_go) pend <= 1'b1;
      else if (byte_done) pend <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          found <= 1'b0;
          dev_idx <= '0;
          mem_size <= '0;
          addr_bytes <= '0;
          id_mfr <= '0;
          id_dev1 <= '0;
          id_dev2 <= '0;
          st <= S_CMD_ID;
        end
        S_CMD_ID: if (got) begin
          cnt <= '0;
          pos <= '0;
          st <= S_RD_ID;
        end
        S_RD_ID: if (got) begin
          cnt <= cnt + 1'b1;
          case (pos)
            2'd0: if (byte_rx != CONT) begin
              id_mfr <= byte_rx;
              pos <= 2'd1;
            end
            2'd1: begin
              id_dev1 <= byte_rx;
              pos <= 2'd2;
            end
            default: begin
              id_dev2 <= byte_rx;
              pos <= 2'd3;
            end
          endcase
          if (pos == 2'd2 || cnt == CW'(MAX_RD - 1)) st <= S_EVAL;
        end
        S_EVAL: begin
          if (pos == 2'd3 && id_mfr == MFR_STD && hit) begin
            found <= 1'b1;
            dev_idx <= hit_idx;
            mem_size <= SZ_W'(DEV_KIB[hit_idx*16 +: 16]) << 10;
            addr_bytes <= DEV_ALEN[hit_idx*2 +: 2];
            done <= 1'b1;
            st <= S_IDLE;
          end else if (pos == 2'd3 && id_mfr == MFR_NONE && FALLBACK_EN) begin
            st <= S_GAP;
          end else begin
            done <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_GAP: st <= S_CMD_SR;
        S_CMD_SR: if (got) st <= S_RD_SR;
        S_RD_SR: if (got) begin
          if ((byte_rx & SR_ZERO) == 8'h00) begin
            found <= 1'b1;
            dev_idx <= IW'(NUM_DEV);
            mem_size <= SZ_W'(FB_KIB) << 10;
            addr_bytes <= FB_ALEN;
          end
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_go_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    byte_go |-> spi_sel);

  a_r10_read_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD_ID) |-> (cnt < CW'(MAX_RD)));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> ($stable(found) && $stable(dev_idx) && $stable(mem_size) && $stable(addr_bytes)));

  a_r4_std_mfr: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found && dev_idx != IW'(NUM_DEV)) |-> (id_mfr == MFR_STD));

  a_r7_fb_source: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found && dev_idx == IW'(NUM_DEV)) |-> (FALLBACK_EN && id_mfr == MFR_NONE));

  a_r8_sr_after_none: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD_SR) |-> (id_mfr == MFR_NONE));

endmodule

// File: tb/fram_id_probe_tb_top.sv
module fram_id_probe_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start_a = 1'b0, start_b = 1'b0;
  logic done_a, done_b, found_a, found_b, sel_a, sel_b, go_a, go_b;
  logic [2:0] idx_a, idx_b;
  logic [31:0] size_a, size_b;
  logic [1:0] alen_a, alen_b;
  logic [7:0] mfr_a, mfr_b, d1_a, d1_b, d2_a, d2_b, tx_a, tx_b;
  logic byte_done = 1'b0;
  logic [7:0] byte_rx = 8'h00;

  fram_id_probe dut_i (
    .clk(clk), .rst_n(rst_n), .start(start_a), .done(done_a), .found(found_a),
    .dev_idx(idx_a), .mem_size(size_a), .addr_bytes(alen_a), .id_mfr(mfr_a),
    .id_dev1(d1_a), .id_dev2(d2_a), .spi_sel(sel_a), .byte_go(go_a),
    .byte_tx(tx_a), .byte_done(byte_done), .byte_rx(byte_rx));

  fram_id_probe #(.FALLBACK_EN(1'b0)) dut_nofb_i (
    .clk(clk), .rst_n(rst_n), .start(start_b), .done(done_b), .found(found_b),
    .dev_idx(idx_b), .mem_size(size_b), .addr_bytes(alen_b), .id_mfr(mfr_b),
    .id_dev1(d1_b), .id_dev2(d2_b), .spi_sel(sel_b), .byte_go(go_b),
    .byte_tx(tx_b), .byte_done(byte_done), .byte_rx(byte_rx));

  // shifter / memory model with frame log
  logic [71:0] scr = '1;
  logic [7:0]  sr_val = 8'h00;
  logic        clr = 1'b0;
  int nfr = 0, cur = 0, bidx = 0, lat = 0, badtx = 0;
  int rd_log [2];
  logic [7:0] cmd_log [2];
  logic [7:0] cur_cmd = 8'h00, rsp = 8'h00;
  logic busy_m = 1'b0, first = 1'b1;
  wire sel_any = sel_a | sel_b;
  wire go_any = go_a | go_b;
  wire [7:0] tx_any = go_a ? tx_a : tx_b;

  always @(posedge clk) begin
    byte_done <= 1'b0;
    if (clr) begin
      nfr <= 0; badtx <= 0; first <= 1'b1; busy_m <= 1'b0;
      rd_log[0] <= 0; rd_log[1] <= 0; cmd_log[0] <= 8'h00; cmd_log[1] <= 8'h00;
    end else begin
      if (!sel_any) first <= 1'b1;
      if (go_any && !busy_m) begin
        busy_m <= 1'b1;
        lat <= 2;
        if (first) begin
          first <= 1'b0;
          if (nfr < 2) cmd_log[nfr] <= tx_any;
          cur <= nfr;
          nfr <= nfr + 1;
          cur_cmd <= tx_any;
          bidx <= 0;
          rsp <= 8'hEE;
        end else begin
          if (tx_any != 8'h00) badtx <= badtx + 1;
          if (cur < 2) rd_log[cur] <= rd_log[cur] + 1;
          if (cur_cmd == 8'h9F) rsp <= (bidx < 9) ? scr[71-8*bidx -: 8] : 8'hFF;
          else rsp <= sr_val;
          bidx <= bidx + 1;
        end
      end else if (busy_m) begin
        if (lat == 0) begin
          byte_done <= 1'b1;
          byte_rx <= rsp;
          busy_m <= 1'b0;
        end else lat <= lat - 1;
      end
    end
  end

  typedef struct {
    bit which; string req;
    logic found; logic [2:0] idx; logic [31:0] size; logic [1:0] alen;
    logic [7:0] mfr, d1, d2;
    int nfr, rd0, rd1; logic [7:0] cmd0, cmd1;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_out(input exp_t e);
    chk(e.req, "found", e.which ? found_b : found_a, e.found);
    chk(e.req, "dev_idx", e.which ? idx_b : idx_a, e.idx);
    chk(e.req, "mem_size", e.which ? size_b : size_a, e.size);
    chk(e.req, "addr_bytes", e.which ? alen_b : alen_a, e.alen);
    chk(e.req, "id_mfr", e.which ? mfr_b : mfr_a, e.mfr);
    chk(e.req, "id_dev1", e.which ? d1_b : d1_a, e.d1);
    chk(e.req, "id_dev2", e.which ? d2_b : d2_a, e.d2);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done_a || done_b) begin
        if (q.size() == 0) chk("R11", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.req, "done source", done_b, e.which);
          cmp_out(e);
          chk("R2", "frames", nfr, e.nfr);
          chk("R2", "cmd frame0", cmd_log[0], e.cmd0);
          chk("R2", "tx filler", badtx, 0);
          chk("R10", "reads frame0", rd_log[0], e.rd0);
          if (e.nfr > 1) begin
            chk("R7", "cmd frame1", cmd_log[1], e.cmd1);
            chk("R7", "reads frame1", rd_log[1], e.rd1);
          end
        end
      end
    end
  end

  task automatic probe(input bit which, input string req, input logic [71:0] s, input logic [7:0] sr,
                       input logic fnd, input logic [2:0] idx, input logic [31:0] size, input logic [1:0] alen,
                       input logic [7:0] m, input logic [7:0] a, input logic [7:0] b,
                       input int nf, input int r0);
    exp_t e;
    e.which = which; e.req = req; e.found = fnd; e.idx = idx; e.size = size; e.alen = alen;
    e.mfr = m; e.d1 = a; e.d2 = b; e.nfr = nf; e.rd0 = r0; e.rd1 = 1;
    e.cmd0 = 8'h9F; e.cmd1 = 8'h05;
    @(negedge clk);
    scr = s; sr_val = sr; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    q.push_back(e);
    if (which) start_b = 1'b1; else start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0; start_b = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    // R11: results held after done, done low
    e.req = "R11";
    cmp_out(e);
    chk("R11", "done low", which ? done_b : done_a, 0);
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done", done_a, 0);
    chk("R1", "found", found_a, 0);
    chk("R1", "spi_sel", sel_a, 0);
    chk("R1", "byte_go", go_a, 0);
    chk("R1", "mem_size", size_a, 0);
    // R4 direct match, no continuation bytes
    probe(0, "R4", {8'hC2, 8'h22, 8'h00, {6{8'hFF}}}, 8'h00, 1, 3'd0, 32'd32768, 2'd2, 8'hC2, 8'h22, 8'h00, 1, 3);
    // R3 two continuation bytes
    probe(0, "R3", {8'h7F, 8'h7F, 8'hC2, 8'h24, 8'h01, {4{8'hFF}}}, 8'h00, 1, 3'd5, 32'd131072, 2'd3, 8'hC2, 8'h24, 8'h01, 1, 5);
    // R3 device byte equal to 0x7F is taken literally
    probe(0, "R3", {8'hC2, 8'h7F, 8'h00, {6{8'hFF}}}, 8'h00, 0, 3'd0, 32'd0, 2'd0, 8'hC2, 8'h7F, 8'h00, 1, 3);
    // R10 ID just fits in nine reads
    probe(0, "R10", {{6{8'h7F}}, 8'hC2, 8'h23, 8'h00}, 8'h00, 1, 3'd2, 32'd65536, 2'd2, 8'hC2, 8'h23, 8'h00, 1, 9);
    // R10 ID one byte too late
    probe(0, "R10", {{7{8'h7F}}, 8'hC2, 8'h23}, 8'h00, 0, 3'd0, 32'd0, 2'd0, 8'hC2, 8'h23, 8'h00, 1, 9);
    // R10 only continuation bytes
    probe(0, "R10", {9{8'h7F}}, 8'h00, 0, 3'd0, 32'd0, 2'd0, 8'h00, 8'h00, 8'h00, 1, 9);
    // R5 unknown family, and revision mismatch
    probe(0, "R5", {8'hC2, 8'h25, 8'h00, {6{8'hFF}}}, 8'h00, 0, 3'd0, 32'd0, 2'd0, 8'hC2, 8'h25, 8'h00, 1, 3);
    probe(0, "R5", {8'hC2, 8'h22, 8'h02, {6{8'hFF}}}, 8'h00, 0, 3'd0, 32'd0, 2'd0, 8'hC2, 8'h22, 8'h02, 1, 3);
    // R6 foreign manufacturer
    probe(0, "R6", {8'h1F, 8'h22, 8'h00, {6{8'hFF}}}, 8'h00, 0, 3'd0, 32'd0, 2'd0, 8'h1F, 8'h22, 8'h00, 1, 3);
    // R7 floating line, status clean
    probe(0, "R7", {9{8'hFF}}, 8'h8C, 1, 3'd6, 32'd262144, 2'd3, 8'hFF, 8'hFF, 8'hFF, 2, 3);
    // R8 status fixed-zero bits set
    probe(0, "R8", {9{8'hFF}}, 8'h10, 0, 3'd0, 32'd0, 2'd0, 8'hFF, 8'hFF, 8'hFF, 2, 3);
    probe(0, "R8", {9{8'hFF}}, 8'h01, 0, 3'd0, 32'd0, 2'd0, 8'hFF, 8'hFF, 8'hFF, 2, 3);
    probe(0, "R8", {9{8'hFF}}, 8'h20, 0, 3'd0, 32'd0, 2'd0, 8'hFF, 8'hFF, 8'hFF, 2, 3);
    // R9 fallback disabled
    probe(1, "R9", {9{8'hFF}}, 8'h00, 0, 3'd0, 32'd0, 2'd0, 8'hFF, 8'hFF, 8'hFF, 1, 3);
    probe(1, "R4", {8'h7F, 8'hC2, 8'h23, 8'h01, {5{8'hFF}}}, 8'h00, 1, 3'd3, 32'd65536, 2'd2, 8'hC2, 8'h23, 8'h01, 1, 4);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule